// File: doc/BRIEF.md
# Stop-Mode Power Controller

This block sequences a small microcontroller core into and out of its lowest-power stop state. The CPU's instruction decoder raises a one-cycle request when it executes a stop instruction. The controller then switches off the main oscillator, holds the CPU clock off, and freezes the port output latches. While stopped, it keeps a clock only on those peripherals that can still count from a source that remains alive.

Any interrupt source that has its request flag set and its mask flag clear ends the stop. The controller turns the oscillator back on and waits a programmable stabilization interval with the CPU still halted. Only then does it return the core to normal running. If such an interrupt is already pending when the stop request arrives, the oscillator is never turned off. The core goes straight into the same halted wait and comes back after the interval.

Peripheral clock enables are driven as one vector. Outside the stop state every enable is high. Inside the stop state each enable follows that peripheral's selected count source and whether the secondary low-speed clock is running.

Top module: `stby_ctrl`

## Requirements
- R1: Once reset has been released, the block is in the running state: osc_en=1, cpu_clk_en=1, stab_busy=0, port_we_ok=1 and periph_en all ones.
- R2: A stop_req pulse in the running state with no unmasked interrupt pending puts the block into the stop state at the next clock edge: osc_en=0, cpu_clk_en=0, stab_busy=0.
- R3: In the stop state, any bit where irq_req=1 and irq_mask=0 causes a wake at the next edge: osc_en=1, stab_busy=1, cpu_clk_en=0. Requests whose mask bit is 1 do not wake the block.
- R4: A stop_req pulse in the running state while an unmasked interrupt is pending goes directly to the stabilization wait. osc_en stays 1, stab_busy=1, cpu_clk_en=0.
- R5: The stabilization wait lasts exactly 2^(STAB_BASE + STAB_STEP*min(stab_sel,4)) clock cycles, with stab_sel sampled when the wait starts. At the end, cpu_clk_en=1 and stab_busy=0. The default values are 12 and 2, so codes 5 to 7 give the same wait as code 4.
- R6: cpu_clk_en is high only in the running state, and stab_busy is high only during the stabilization wait.
- R7: port_we_ok is 0 in the stop state and 1 in every other state.
- R8: In the stop state, periph_en bits 0 to 3 are 0. These are the 16-bit timer, the watchdog, the A/D converter and the multiplier.
- R9: In the stop state, periph_en[4] (watch timer) equals wt_src_sub & sub_clk_on, and periph_en[5] (LCD driver) equals lcd_src_sub & sub_clk_on.
- R10: In the stop state, periph_en[6] (8-bit timer A) equals tmra_src_ext, and periph_en[7] (8-bit timer B) equals tmrb_src_ext.
- R11: In the stop state, periph_en[8] (8-bit timer C) depends on tmrc_src. Code 0 (main clock) gives 0. Code 1 (secondary clock) gives sub_clk_on. Codes 2 and 3 (timer A output) give timer A's own enable.
- R12: stop_req is ignored during the stabilization wait and in the stop state. The state and the length of the wait are unchanged.
- R13: Outside the stop state, periph_en is all ones, including during the stabilization wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst | input | 1 | Synchronous active-high reset |
| stop_req | input | 1 | One-cycle stop request from the instruction decoder |
| irq_req | input | NUM_IRQ | Interrupt request flags |
| irq_mask | input | NUM_IRQ | Interrupt mask flags (1 = masked) |
| stab_sel | input | SEL_W | Stabilization wait selection code |
| sub_clk_on | input | 1 | Secondary clock is running |
| wt_src_sub | input | 1 | Watch timer counts from the secondary clock |
| lcd_src_sub | input | 1 | LCD driver counts from the secondary clock |
| tmra_src_ext | input | 1 | Timer A counts from its external input |
| tmrb_src_ext | input | 1 | Timer B counts from its external input |
| tmrc_src | input | 2 | Timer C count source: 0 main, 1 secondary, 2/3 timer A output |
| osc_en | output | 1 | Main oscillator enable |
| cpu_clk_en | output | 1 | CPU clock enable |
| stab_busy | output | 1 | Stabilization wait in progress |
| port_we_ok | output | 1 | Port output latch writes permitted |
| periph_en | output | 9 | Per-peripheral clock enables |

## Verification
The bound checker checks these rules on every cycle:
- The CPU clock is never on while the oscillator is off.
- The CPU clock only turns on straight after a stabilization wait.
- The always-off peripherals and the port write permission are low whenever the oscillator is off.
- An unmasked request in the stop state always starts a wait.
- A stop request during a wait never turns the oscillator off.
- No wait is shorter than the shortest code allows.

Only the bench's scenarios can show the following:
- The exact wait length for each selection code, including the saturating codes.
- That masked requests leave the stop state untouched.
- The full source-selection matrix of peripheral enables in the stop state, which the bench sweeps exhaustively.

// File: rtl/stby_pkg.sv
package stby_pkg;
  typedef enum logic [1:0] {
    PM_RUN  = 2'd0,
    PM_STOP = 2'd1,
    PM_HOLD = 2'd2
  } pm_state_e;

  localparam int PE_W    = 9;
  localparam int PE_T16  = 0;
  localparam int PE_WDT  = 1;
  localparam int PE_ADC  = 2;
  localparam int PE_MUL  = 3;
  localparam int PE_WT   = 4;
  localparam int PE_LCD  = 5;
  localparam int PE_TMRA = 6;
  localparam int PE_TMRB = 7;
  localparam int PE_TMRC = 8;
  localparam int PE_OFF_N = 4;

  localparam logic [1:0] CSRC_MAIN = 2'd0;
  localparam logic [1:0] CSRC_SUB  = 2'd1;
endpackage

// File: rtl/stby_fsm.sv
module stby_fsm
  import stby_pkg::*;
#(
  parameter int NUM_IRQ = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               stop_req,
  input  logic [NUM_IRQ-1:0] irq_req,
  input  logic [NUM_IRQ-1:0] irq_mask,
  input  logic               stab_done,
  output pm_state_e          state_q,
  output pm_state_e          state_d,
  output logic               hold_start
);
  logic wake;

  assign wake = |(irq_req & ~irq_mask);

  always_comb begin
    state_d = state_q;
    case (state_q)
      PM_RUN:  if (stop_req) state_d = wake ? PM_HOLD : PM_STOP;
      PM_STOP: if (wake) state_d = PM_HOLD;
      PM_HOLD: if (stab_done) state_d = PM_RUN;
      default: state_d = PM_RUN;
    endcase
  end

  assign hold_start = (state_d == PM_HOLD) && (state_q != PM_HOLD);

  always_ff @(posedge clk) begin
    if (rst) state_q <= PM_RUN;
    else     state_q <= state_d;
  end
endmodule

// File: rtl/stby_stab_cnt.sv
module stby_stab_cnt #(
  parameter int SEL_W    = 3,
  parameter int BASE     = 12,
  parameter int STEP     = 2,
  parameter int MAX_CODE = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             active,
  input  logic [SEL_W-1:0] sel,
  output logic             done
);
  localparam int CNT_W = BASE + STEP * MAX_CODE + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim_q;

  function automatic logic [CNT_W-1:0] wait_len(input logic [SEL_W-1:0] s);
    int code;
    code = (int'(s) > MAX_CODE) ? MAX_CODE : int'(s);
    return CNT_W'(1) << (BASE + STEP * code);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      lim_q <= CNT_W'(1) << BASE;
    end else if (start) begin
      cnt_q <= '0;
      lim_q <= wait_len(sel);
    end else if (active) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign done = active && (cnt_q == lim_q - CNT_W'(1));
endmodule

// File: rtl/stby_gate.sv
module stby_gate
  import stby_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            stop_d,
  input  logic            sub_clk_on,
  input  logic            wt_src_sub,
  input  logic            lcd_src_sub,
  input  logic            tmra_src_ext,
  input  logic            tmrb_src_ext,
  input  logic [1:0]      tmrc_src,
  output logic [PE_W-1:0] periph_en
);
  logic [PE_W-1:0] stop_en;

  always_comb begin
    for (int i = 0; i < PE_OFF_N; i++) stop_en[i] = 1'b0;
    stop_en[PE_WT]   = wt_src_sub & sub_clk_on;
    stop_en[PE_LCD]  = lcd_src_sub & sub_clk_on;
    stop_en[PE_TMRA] = tmra_src_ext;
    stop_en[PE_TMRB] = tmrb_src_ext;
    case (tmrc_src)
      CSRC_MAIN: stop_en[PE_TMRC] = 1'b0;
      CSRC_SUB:  stop_en[PE_TMRC] = sub_clk_on;
      default:   stop_en[PE_TMRC] = tmra_src_ext;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         periph_en <= '1;
    else if (stop_d) periph_en <= stop_en;
    else             periph_en <= '1;
  end
endmodule

// File: rtl/stby_ctrl.sv
module stby_ctrl
  import stby_pkg::*;
#(
  parameter int NUM_IRQ    = 8,
  parameter int SEL_W      = 3,
  parameter int STAB_BASE  = 12,
  parameter int STAB_STEP  = 2,
  parameter int STAB_CODES = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               stop_req,
  input  logic [NUM_IRQ-1:0] irq_req,
  input  logic [NUM_IRQ-1:0] irq_mask,
  input  logic [SEL_W-1:0]   stab_sel,
  input  logic               sub_clk_on,
  input  logic               wt_src_sub,
  input  logic               lcd_src_sub,
  input  logic               tmra_src_ext,
  input  logic               tmrb_src_ext,
  input  logic [1:0]         tmrc_src,
  output logic               osc_en,
  output logic               cpu_clk_en,
  output logic               stab_busy,
  output logic               port_we_ok,
  output logic [PE_W-1:0]    periph_en
);
  localparam int MAX_CODE = STAB_CODES - 1;

  pm_state_e state_q;
  pm_state_e state_d;
  logic      hold_start;
  logic      stab_done;

  stby_fsm #(.NUM_IRQ(NUM_IRQ)) fsm_i (
    .clk(clk), .rst(rst), .stop_req(stop_req),
    .irq_req(irq_req), .irq_mask(irq_mask), .stab_done(stab_done),
    .state_q(state_q), .state_d(state_d), .hold_start(hold_start)
  );

  stby_stab_cnt #(
    .SEL_W(SEL_W), .BASE(STAB_BASE), .STEP(STAB_STEP), .MAX_CODE(MAX_CODE)
  ) cnt_i (
    .clk(clk), .rst(rst), .start(hold_start),
    .active(state_q == PM_HOLD), .sel(stab_sel), .done(stab_done)
  );

  stby_gate gate_i (
    .clk(clk), .rst(rst), .stop_d(state_d == PM_STOP),
    .sub_clk_on(sub_clk_on), .wt_src_sub(wt_src_sub), .lcd_src_sub(lcd_src_sub),
    .tmra_src_ext(tmra_src_ext), .tmrb_src_ext(tmrb_src_ext),
    .tmrc_src(tmrc_src), .periph_en(periph_en)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      osc_en     <= 1'b1;
      cpu_clk_en <= 1'b1;
      stab_busy  <= 1'b0;
      port_we_ok <= 1'b1;
    end else begin
      osc_en     <= (state_d != PM_STOP);
      cpu_clk_en <= (state_d == PM_RUN);
      stab_busy  <= (state_d == PM_HOLD);
      port_we_ok <= (state_d != PM_STOP);
    end
  end
endmodule

// File: rtl/stby_ctrl_chk.sv
module stby_ctrl_chk #(
  parameter int NUM_IRQ   = 8,
  parameter int STAB_BASE = 12,
  parameter int PE_W      = 9
) (
  input logic               clk,
  input logic               rst,
  input logic               stop_req,
  input logic [NUM_IRQ-1:0] irq_req,
  input logic [NUM_IRQ-1:0] irq_mask,
  input logic               osc_en,
  input logic               cpu_clk_en,
  input logic               stab_busy,
  input logic               port_we_ok,
  input logic [PE_W-1:0]    periph_en
);
  logic [31:0] busy_len;

  always_ff @(posedge clk) begin
    if (rst)            busy_len <= '0;
    else if (stab_busy) busy_len <= busy_len + 32'd1;
    else                busy_len <= '0;
  end

  AST_CPU_NEEDS_OSC: assert property (@(posedge clk) disable iff (rst)
    !osc_en |-> !cpu_clk_en && !stab_busy); // R6
  AST_RUN_AFTER_WAIT: assert property (@(posedge clk) disable iff (rst)
    $rose(cpu_clk_en) |-> $past(stab_busy)); // R5
  AST_WAIT_MIN_LEN: assert property (@(posedge clk) disable iff (rst)
    $fell(stab_busy) |-> busy_len >= (32'd1 << STAB_BASE)); // R5
  AST_PORT_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !osc_en |-> !port_we_ok); // R7
  AST_CORE_PERIPH_OFF: assert property (@(posedge clk) disable iff (rst)
    !osc_en |-> periph_en[3:0] == 4'b0000); // R8
  AST_UNMASKED_WAKE: assert property (@(posedge clk) disable iff (rst)
    (!osc_en && |(irq_req & ~irq_mask)) |=> stab_busy && osc_en); // R3
  AST_WAIT_IGNORES_STOP: assert property (@(posedge clk) disable iff (rst)
    (stab_busy && stop_req) |=> osc_en); // R12
  AST_OUTSIDE_STOP_ALL_ON: assert property (@(posedge clk) disable iff (rst)
    osc_en |-> &periph_en); // R13
endmodule

bind stby_ctrl stby_ctrl_chk #(.NUM_IRQ(NUM_IRQ), .STAB_BASE(STAB_BASE), .PE_W(9)) chk_i (
  .clk(clk), .rst(rst), .stop_req(stop_req), .irq_req(irq_req), .irq_mask(irq_mask),
  .osc_en(osc_en), .cpu_clk_en(cpu_clk_en), .stab_busy(stab_busy),
  .port_we_ok(port_we_ok), .periph_en(periph_en)
);

// File: tb/stby_ctrl_tb.sv
`timescale 1ns/1ps
module stby_ctrl_tb_top;
  localparam int NI = 4;
  localparam int BASE = 2;
  localparam int STEP = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stop_req = 1'b0;
  logic [NI-1:0] irq_req = '0;
  logic [NI-1:0] irq_mask = '1;
  logic [2:0] stab_sel = '0;
  logic sub_clk_on = 1'b0, wt_src_sub = 1'b0, lcd_src_sub = 1'b0;
  logic tmra_src_ext = 1'b0, tmrb_src_ext = 1'b0;
  logic [1:0] tmrc_src = '0;
  logic osc_en, cpu_clk_en, stab_busy, port_we_ok;
  logic [8:0] periph_en;

  int n_chk = 0;
  int n_bad = 0;
  bit done_flag = 0;

  always #2.5 clk = ~clk;

  stby_ctrl #(.NUM_IRQ(NI), .STAB_BASE(BASE), .STAB_STEP(STEP)) dut_i (
    .clk(clk), .rst(rst), .stop_req(stop_req), .irq_req(irq_req), .irq_mask(irq_mask),
    .stab_sel(stab_sel), .sub_clk_on(sub_clk_on), .wt_src_sub(wt_src_sub),
    .lcd_src_sub(lcd_src_sub), .tmra_src_ext(tmra_src_ext), .tmrb_src_ext(tmrb_src_ext),
    .tmrc_src(tmrc_src), .osc_en(osc_en), .cpu_clk_en(cpu_clk_en),
    .stab_busy(stab_busy), .port_we_ok(port_we_ok), .periph_en(periph_en)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int wait_of(input int s);
    int c;
    c = (s > 4) ? 4 : s;
    return 1 << (BASE + STEP * c);
  endfunction

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // Count busy samples, pulsing stop_req at the second one (R12).
  task automatic measure_hold(input int exp_len);
    int n;
    n = 0;
    while (stab_busy === 1'b1 && n < 5000) begin
      n++;
      if (n == 2) stop_req = 1'b1;
      step();
      stop_req = 1'b0;
      if (n == 2) check("R12 osc stays on after stop_req in wait", 32'(osc_en), 32'd1);
    end
    check("R5 wait length", n, exp_len);
    check("R5 cpu clock back", 32'(cpu_clk_en), 32'd1);
    check("R6 busy cleared", 32'(stab_busy), 32'd0);
    check("R13 periph all on after wait", 32'(periph_en), 32'h1FF);
    check("R7 port writes allowed", 32'(port_we_ok), 32'd1);
  endtask

  task automatic enter_stop();
    irq_req = '0;
    stop_req = 1'b1;
    step();
    stop_req = 1'b0;
    check("R2 osc off", 32'(osc_en), 32'd0);
    check("R2 cpu off", 32'(cpu_clk_en), 32'd0);
    check("R6 busy off in stop", 32'(stab_busy), 32'd0);
    check("R7 port writes blocked", 32'(port_we_ok), 32'd0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin : main
    logic [8:0] exp_pe;
    repeat (3) step();
    rst = 1'b0;
    step();
    check("R1 osc", 32'(osc_en), 32'd1);
    check("R1 cpu", 32'(cpu_clk_en), 32'd1);
    check("R1 busy", 32'(stab_busy), 32'd0);
    check("R1 port", 32'(port_we_ok), 32'd1);
    check("R1 periph", 32'(periph_en), 32'h1FF);

    for (int s = 0; s < 8; s++) begin
      stab_sel = 3'(s);
      // Stop path, then wake
      enter_stop();
      stop_req = 1'b1;
      step();
      stop_req = 1'b0;
      check("R12 stop_req in stop ignored", 32'(osc_en), 32'd0);
      if (s == 0) begin
        for (int r = 0; r < (1 << NI); r++) begin
          for (int m = 0; m < (1 << NI); m++) begin
            if ((r & ~m & ((1 << NI) - 1)) == 0) begin
              irq_req = NI'(r);
              irq_mask = NI'(m);
              step();
              check("R3 masked request no wake", 32'(osc_en), 32'd0);
            end
          end
        end
        irq_req = '0;
      end
      irq_mask = '0;
      irq_req = NI'(1 << (s % NI));
      step();
      irq_req = '0;
      irq_mask = '1;
      check("R3 wake busy", 32'(stab_busy), 32'd1);
      check("R3 wake osc on", 32'(osc_en), 32'd1);
      check("R3 wake cpu still off", 32'(cpu_clk_en), 32'd0);
      check("R13 periph on during wait", 32'(periph_en), 32'h1FF);
      measure_hold(wait_of(s));

      // Pending path
      irq_mask = '0;
      irq_req = NI'(1 << ((s + 1) % NI));
      stop_req = 1'b1;
      step();
      stop_req = 1'b0;
      irq_req = '0;
      irq_mask = '1;
      check("R4 osc stays on", 32'(osc_en), 32'd1);
      check("R4 busy", 32'(stab_busy), 32'd1);
      check("R4 cpu off", 32'(cpu_clk_en), 32'd0);
      check("R7 port writes allowed in wait", 32'(port_we_ok), 32'd1);
      measure_hold(wait_of(s));
    end

    // Peripheral gating sweep in stop
    stab_sel = 3'd0;
    enter_stop();
    for (int v = 0; v < 128; v++) begin
      sub_clk_on   = v[0];
      wt_src_sub   = v[1];
      lcd_src_sub  = v[2];
      tmra_src_ext = v[3];
      tmrb_src_ext = v[4];
      tmrc_src     = v[6:5];
      step();
      exp_pe = '0;
      exp_pe[4] = v[1] & v[0];
      exp_pe[5] = v[2] & v[0];
      exp_pe[6] = v[3];
      exp_pe[7] = v[4];
      exp_pe[8] = (v[6:5] == 2'd0) ? 1'b0 : (v[6:5] == 2'd1) ? v[0] : v[3];
      check("R8 always-off group", 32'(periph_en[3:0]), 32'(exp_pe[3:0]));
      check("R9 secondary-clock peripherals", 32'(periph_en[5:4]), 32'(exp_pe[5:4]));
      check("R10 external-input timers", 32'(periph_en[7:6]), 32'(exp_pe[7:6]));
      check("R11 chained timer", 32'(periph_en[8]), 32'(exp_pe[8]));
    end
    irq_mask = '0;
    irq_req = NI'(1);
    step();
    irq_req = '0;
    irq_mask = '1;
    check("R13 periph on after wake", 32'(periph_en), 32'h1FF);
    measure_hold(wait_of(0));
    finish_run();
  end
endmodule